// File: doc/BRIEF.md
# Slave FIFO Packet Write Controller

This controller lives on the host-logic side of an external slave FIFO that feeds a USB IN endpoint. It takes a stream of data words, each with an optional end-of-packet marker, from upstream logic through a valid/ready handshake. It produces the remote FIFO's write strobe, data bus, endpoint-select lines and packet-end strobe. Every output comes from a register clocked by the interface clock. The bus carries one byte per word in narrow mode and two bytes per word in wide mode.

The remote FIFO can close a packet on its own once its byte count reaches a programmed auto-commit length. The controller keeps its own copy of that count, so it knows which packets close themselves and which ones need a manual packet-end strobe.

One corner case needs care: a manual packet-end issued in the cycle right after the word that triggered an automatic commit. This covers both a one-word packet and a zero-length packet. The controller holds the packet-end strobe back by one extra cycle in that case. An optional asynchronous-strobe mode stretches packet-end to a minimum pulse width given in picoseconds. It then enforces the same minimum low time before anything else may happen.

The control FSM has four states:
- `ST_IDLE` accepts words.
- `ST_GAP` is the one-cycle hold-back.
- `ST_END` drives packet-end.
- `ST_REST` is the asynchronous low-time recovery.

Its transitions are:
- IDLE→END on a last word that does not reach the auto-commit length, or on a zero-length request.
- IDLE→GAP in the same two cases when the previous accepted word auto-committed.
- GAP→END unconditionally.
- END→IDLE in synchronous mode.
- END→REST when the pulse timer expires in asynchronous mode.
- REST→IDLE when the timer expires again.

Top module: `pkt_wr_ctrl`

## Requirements
- R1: While reset is asserted, and directly after it is released, `fifo_wr` and `pkt_end` are low and `fifo_addr` is zero. `in_ready` is high whenever `fifo_full` is low.
- R2: A word is taken at a clock edge where `in_valid` and `in_ready` are both high. In the following cycle `fifo_wr` is high for exactly one cycle. In that cycle `fifo_data` equals the word when `wide_mode`=1. When `wide_mode`=0, `fifo_data` holds only the low byte, with the upper byte zero.
- R3: While `fifo_full` is high, `in_ready` is low and no write strobe is produced.
- R4: Each accepted word adds 1 byte to the packet count when `wide_mode`=0 and 2 bytes when `wide_mode`=1. With `auto_mode`=1, the word that brings the count to `auto_len` or beyond closes the packet without any `pkt_end`. The count then restarts at zero.
- R5: A last-marked word that does not reach `auto_len` raises `pkt_end` in the same cycle as its `fifo_wr`. In synchronous mode (`async_mode`=0) that pulse lasts one cycle, and `in_ready` is low while `pkt_end` is high.
- R6: A last-marked word that exactly reaches `auto_len` produces no `pkt_end`.
- R7: A manual end is delayed when the previously accepted word, one cycle earlier, auto-committed. For a one-word packet, `pkt_end` rises one cycle after that word's `fifo_wr` instead of with it. For a zero-length packet, one empty cycle precedes the pulse.
- R8: Raising `zlp_req` in `ST_IDLE` while the packet count is zero produces a `pkt_end` pulse with no write. When the count is nonzero, `zlp_req` is ignored and no `pkt_end` occurs.
- R9: With `async_mode`=1, `pkt_end` stays high for ceil(`PULSE_MIN_PS`/`CLK_PERIOD_PS`) cycles (13 at the defaults). After it falls, `in_ready` stays low for the same number of cycles.
- R10: `fifo_addr` takes the value of `ep_sel` only when all of the following hold: the FSM is in `ST_IDLE`, `in_valid` and `zlp_req` are low, and no write strobe is active. At any other time `fifo_addr` keeps its value.
- R11: With `auto_mode`=0, no packet closes by count, and every last-marked word raises `pkt_end` together with its write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wide_mode | input | 1 | 1: two bytes per word, 0: one byte per word |
| auto_mode | input | 1 | 1: remote FIFO closes packets at `auto_len` bytes |
| async_mode | input | 1 | 1: stretched packet-end pulse with recovery time |
| auto_len | input | LEN_W | Auto-commit length in bytes |
| ep_sel | input | ADDR_W | Requested endpoint select |
| in_valid | input | 1 | Upstream word valid |
| in_data | input | 2*BYTE_W | Upstream word |
| in_last | input | 1 | Word ends its packet |
| in_ready | output | 1 | Controller can take a word |
| zlp_req | input | 1 | Request a zero-length packet |
| fifo_full | input | 1 | Remote FIFO full flag |
| fifo_wr | output | 1 | Registered write strobe |
| fifo_data | output | 2*BYTE_W | Registered data bus |
| fifo_addr | output | ADDR_W | Registered endpoint-select lines |
| pkt_end | output | 1 | Registered packet-end strobe |

## Verification
The embedded assertions check four rules on every cycle:
- No packet-end appears alongside an auto-committing write, nor in the cycle after one.
- A synchronous pulse lasts exactly one cycle, and an asynchronous pulse is never shorter than the computed width.
- The endpoint lines move only when the strobes are quiet, both in the current cycle and the one before.
- A write never follows a cycle in which the full flag was high.

Some behaviour can only be shown by the bench's scenarios:
- The count arithmetic in both bus widths.
- Which particular word carries packet-end.
- The delayed pulse after a zero-length request.
- A zero-length request being ignored while bytes are pending.
- The asynchronous recovery length.

// File: rtl/pwc_pkg.sv
package pwc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_GAP  = 2'd1,
        ST_END  = 2'd2,
        ST_REST = 2'd3
    } pwc_state_e;

    function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
        return (num + den - 1) / den;
    endfunction

endpackage

// File: rtl/pwc_byte_cnt.sv
module pwc_byte_cnt #(
    parameter int unsigned LEN_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc,
    input  logic             last,
    input  logic             wide,
    input  logic             auto_en,
    input  logic [LEN_W-1:0] auto_len,
    output logic             auto_hit,
    output logic             cnt_zero
);

    logic [LEN_W-1:0] cnt_q;
    logic [LEN_W:0]   sum;

    // advance by one byte per narrow word, two per wide word
    assign sum      = {1'b0, cnt_q} + {{(LEN_W-1){1'b0}}, wide, ~wide};
    assign auto_hit = acc && auto_en && (sum >= {1'b0, auto_len});
    assign cnt_zero = (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (acc) begin
            cnt_q <= (auto_hit || last) ? '0 : sum[LEN_W-1:0];
        end
    end

endmodule

// File: rtl/pwc_hold_timer.sv
module pwc_hold_timer #(
    parameter int unsigned CYC = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);

    localparam int unsigned TW = (CYC < 2) ? 1 : $clog2(CYC + 1);

    logic [TW-1:0] cnt_q;

    assign done = (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= TW'(CYC - 1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/pkt_wr_ctrl.sv
module pkt_wr_ctrl
    import pwc_pkg::*;
#(
    parameter int unsigned BYTE_W        = 8,
    parameter int unsigned LEN_W         = 11,
    parameter int unsigned ADDR_W        = 2,
    parameter int unsigned CLK_PERIOD_PS = 4000,
    parameter int unsigned PULSE_MIN_PS  = 50000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wide_mode,
    input  logic                  auto_mode,
    input  logic                  async_mode,
    input  logic [LEN_W-1:0]      auto_len,
    input  logic [ADDR_W-1:0]     ep_sel,
    input  logic                  in_valid,
    input  logic [2*BYTE_W-1:0]   in_data,
    input  logic                  in_last,
    output logic                  in_ready,
    input  logic                  zlp_req,
    input  logic                  fifo_full,
    output logic                  fifo_wr,
    output logic [2*BYTE_W-1:0]   fifo_data,
    output logic [ADDR_W-1:0]     fifo_addr,
    output logic                  pkt_end
);

    localparam int unsigned LANES     = 2;
    localparam int unsigned DATA_W    = LANES * BYTE_W;
    localparam int unsigned RAW_CYC   = ceil_div(PULSE_MIN_PS, CLK_PERIOD_PS);
    localparam int unsigned PULSE_CYC = (RAW_CYC == 0) ? 1 : RAW_CYC;
    localparam int unsigned HW        = $clog2(PULSE_CYC + 2);

    pwc_state_e state_q, state_n;

    logic              acc;
    logic              auto_hit;
    logic              cnt_zero;
    logic              tmr_start;
    logic              tmr_done;
    logic              addr_upd;
    logic              fifo_wr_q;
    logic              end_q;
    logic              auto_q;
    logic [DATA_W-1:0] fifo_data_q;
    logic [ADDR_W-1:0] fifo_addr_q;
    logic [DATA_W-1:0] lane_d;

    // byte lanes: lane 0 always passes, upper lanes only in wide mode
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        if (l == 0) begin : g_low
            assign lane_d[BYTE_W-1:0] = in_data[BYTE_W-1:0];
        end else begin : g_high
            assign lane_d[l*BYTE_W +: BYTE_W] = wide_mode ? in_data[l*BYTE_W +: BYTE_W] : '0;
        end
    end

    assign in_ready = (state_q == ST_IDLE) && !fifo_full;
    assign acc      = in_valid && in_ready;
    assign addr_upd = (state_q == ST_IDLE) && !in_valid && !zlp_req && !fifo_wr_q;

    pwc_byte_cnt #(
        .LEN_W (LEN_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc      (acc),
        .last     (in_last),
        .wide     (wide_mode),
        .auto_en  (auto_mode),
        .auto_len (auto_len),
        .auto_hit (auto_hit),
        .cnt_zero (cnt_zero)
    );

    pwc_hold_timer #(
        .CYC (PULSE_CYC)
    ) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .done  (tmr_done)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_n;
        end
    end

    // next-state logic
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (acc) begin
                    if (in_last && !auto_hit) begin
                        state_n = auto_q ? ST_GAP : ST_END;
                    end
                end else if (zlp_req && cnt_zero) begin
                    state_n = auto_q ? ST_GAP : ST_END;
                end
            end
            ST_GAP:  state_n = ST_END;
            ST_END: begin
                if (!async_mode) begin
                    state_n = ST_IDLE;
                end else if (tmr_done) begin
                    state_n = ST_REST;
                end
            end
            ST_REST: begin
                if (tmr_done) begin
                    state_n = ST_IDLE;
                end
            end
            default: state_n = ST_IDLE;
        endcase
        tmr_start = (state_n != state_q) && ((state_n == ST_END) || (state_n == ST_REST));
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fifo_wr_q   <= 1'b0;
            end_q       <= 1'b0;
            auto_q      <= 1'b0;
            fifo_data_q <= '0;
            fifo_addr_q <= '0;
        end else begin
            fifo_wr_q <= acc;
            end_q     <= (state_n == ST_END);
            auto_q    <= auto_hit;
            if (acc) begin
                fifo_data_q <= lane_d;
            end
            if (addr_upd) begin
                fifo_addr_q <= ep_sel;
            end
        end
    end

    assign fifo_wr   = fifo_wr_q;
    assign pkt_end   = end_q;
    assign fifo_data = fifo_data_q;
    assign fifo_addr = fifo_addr_q;

    // high-run length of packet-end, used only by the width check
    logic [HW-1:0] hi_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt <= '0;
        end else if (!pkt_end) begin
            hi_cnt <= '0;
        end else if (hi_cnt != '1) begin
            hi_cnt <= hi_cnt + 1'b1;
        end
    end

    AST_NO_WR_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n) fifo_wr |-> $past(!fifo_full)); // R3
    AST_AUTO_NO_END: assert property (@(posedge clk) disable iff (!rst_n) auto_q |-> !pkt_end); // R6
    AST_END_SPACING: assert property (@(posedge clk) disable iff (!rst_n) auto_q |=> !pkt_end); // R7
    AST_SYNC_PULSE: assert property (@(posedge clk) disable iff (!rst_n) (pkt_end && !async_mode) |=> !pkt_end); // R5
    AST_ASYNC_WIDTH: assert property (@(posedge clk) disable iff (!rst_n) ($fell(pkt_end) && async_mode) |-> (hi_cnt >= HW'(PULSE_CYC))); // R9
    AST_ADDR_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !$stable(fifo_addr) |-> (!fifo_wr && !pkt_end && !$past(fifo_wr) && !$past(pkt_end))); // R10

endmodule

// File: tb/pkt_wr_ctrl_tb.sv
`timescale 1ns/1ps
module pkt_wr_ctrl_tb;

    localparam int PW = (50000 + 4000 - 1) / 4000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wide_mode = 1'b0;
    logic        auto_mode = 1'b1;
    logic        async_mode = 1'b0;
    logic [10:0] auto_len = 11'd4;
    logic [1:0]  ep_sel = 2'd0;
    logic        in_valid = 1'b0;
    logic [15:0] in_data = 16'h0;
    logic        in_last = 1'b0;
    logic        in_ready;
    logic        zlp_req = 1'b0;
    logic        fifo_full = 1'b0;
    logic        fifo_wr;
    logic [15:0] fifo_data;
    logic [1:0]  fifo_addr;
    logic        pkt_end;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int last_auto = -100;
    int mcnt = 0;
    bit finished = 1'b0;

    logic [17:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pkt_wr_ctrl u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wide_mode  (wide_mode),
        .auto_mode  (auto_mode),
        .async_mode (async_mode),
        .auto_len   (auto_len),
        .ep_sel     (ep_sel),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_last    (in_last),
        .in_ready   (in_ready),
        .zlp_req    (zlp_req),
        .fifo_full  (fifo_full),
        .fifo_wr    (fifo_wr),
        .fifo_data  (fifo_data),
        .fifo_addr  (fifo_addr),
        .pkt_end    (pkt_end)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push(input bit wr, input bit en, input logic [15:0] d, input string tag);
        exp_q.push_back({wr, en, wr ? d : 16'h0});
        tag_q.push_back(tag);
    endtask

    // scoreboard monitor
    logic [17:0] got;
    logic [17:0] want;
    string       wtag;
    always @(negedge clk) begin
        if (rst_n && (fifo_wr || pkt_end)) begin
            got = {fifo_wr, pkt_end, fifo_wr ? fifo_data : 16'h0};
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2 unexpected output", 32'(got), 32'h0);
            end else begin
                want = exp_q.pop_front();
                wtag = tag_q.pop_front();
                chk(got == want, wtag, 32'(got), 32'(want));
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [15:0] d, input bit last);
        logic [15:0] ed;
        bit          adj;
        bit          hit;
        in_valid = 1'b1;
        in_data  = d;
        in_last  = last;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        ed   = wide_mode ? d : {8'h00, d[7:0]};
        mcnt = mcnt + (wide_mode ? 2 : 1);
        hit  = auto_mode && (mcnt >= int'(auto_len));
        adj  = (cyc == last_auto + 1);
        if (hit) begin
            push(1'b1, 1'b0, ed, last ? "R6" : "R4");
            mcnt = 0;
            last_auto = cyc;
        end else if (last) begin
            mcnt = 0;
            if (adj) begin
                push(1'b1, 1'b0, ed, "R7");
                push(1'b0, 1'b1, 16'h0, "R7");
            end else begin
                push(1'b1, 1'b1, ed, auto_mode ? "R5" : "R11");
            end
            if (async_mode) repeat (PW - 1) push(1'b0, 1'b1, 16'h0, "R9");
        end else begin
            push(1'b1, 1'b0, ed, "R2");
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic zlp();
        zlp_req = 1'b1;
        if (mcnt == 0) push(1'b0, 1'b1, 16'h0, "R8");
        @(negedge clk);
        zlp_req = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=hang expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int lo;
        idle(3);
        // R1: reset state
        chk(fifo_wr == 1'b0, "R1 fifo_wr", 32'(fifo_wr), 32'h0);
        chk(pkt_end == 1'b0, "R1 pkt_end", 32'(pkt_end), 32'h0);
        chk(fifo_addr == 2'd0, "R1 fifo_addr", 32'(fifo_addr), 32'h0);
        chk(in_ready == 1'b1, "R1 in_ready", 32'(in_ready), 32'h1);
        rst_n = 1'b1;
        idle(2);
        chk(in_ready == 1'b1, "R1 in_ready after reset", 32'(in_ready), 32'h1);

        // R4/R6/R2: narrow mode, packet exactly reaches length 4
        send(16'h55A1, 1'b0);
        send(16'h55A2, 1'b0);
        send(16'h55A3, 1'b0);
        send(16'h55A4, 1'b1);
        idle(3);
        // R5: short narrow packet
        send(16'h00B1, 1'b0);
        send(16'h00B2, 1'b0);
        send(16'h00B3, 1'b1);
        chk(in_ready == 1'b0, "R5 in_ready during pkt_end", 32'(in_ready), 32'h0);
        idle(3);

        // R7: wide mode, full packet then adjacent one-word packet
        wide_mode = 1'b1;
        auto_len  = 11'd8;
        for (int i = 0; i < 4; i++) send(16'hC100 + 16'(i), 1'b0);
        send(16'hC1FF, 1'b1);
        idle(3);
        // R5: one-word packet two cycles after an auto-commit
        for (int i = 0; i < 4; i++) send(16'hD100 + 16'(i), 1'b0);
        idle(2);
        send(16'hD1FF, 1'b1);
        idle(3);

        // R8: zero-length packet with empty count, then ignored with bytes pending
        zlp();
        idle(3);
        send(16'hE101, 1'b0);
        idle(2);
        zlp();
        chk(pkt_end == 1'b0, "R8 zlp ignored", 32'(pkt_end), 32'h0);
        idle(2);
        chk(pkt_end == 1'b0, "R8 zlp ignored later", 32'(pkt_end), 32'h0);
        send(16'hE102, 1'b1);
        idle(3);

        // R7: zero-length request right after an auto-commit
        for (int i = 0; i < 4; i++) send(16'hF100 + 16'(i), 1'b0);
        zlp_req = 1'b1;
        push(1'b0, 1'b1, 16'h0, "R7");
        @(negedge clk);
        zlp_req = 1'b0;
        chk(pkt_end == 1'b0, "R7 zlp gap cycle", 32'(pkt_end), 32'h0);
        @(negedge clk);
        chk(pkt_end == 1'b1, "R7 zlp delayed pulse", 32'(pkt_end), 32'h1);
        idle(3);

        // R11: auto mode off, count passes the length
        auto_mode = 1'b0;
        for (int i = 0; i < 5; i++) send(16'h7100 + 16'(i), 1'b0);
        send(16'h71FF, 1'b1);
        idle(3);
        auto_mode = 1'b1;

        // R3: full flag stalls the handshake
        fifo_full = 1'b1;
        fork
            send(16'h3333, 1'b1);
            begin
                idle(4);
                chk(in_ready == 1'b0, "R3 in_ready while full", 32'(in_ready), 32'h0);
                chk(fifo_wr == 1'b0, "R3 no write while full", 32'(fifo_wr), 32'h0);
                fifo_full = 1'b0;
            end
        join
        idle(3);

        // R10: endpoint lines
        ep_sel = 2'd2;
        @(negedge clk);
        chk(fifo_addr == 2'd2, "R10 address loads when idle", 32'(fifo_addr), 32'h2);
        fifo_full = 1'b1;
        in_valid  = 1'b1;
        in_data   = 16'h9999;
        ep_sel    = 2'd3;
        idle(3);
        chk(fifo_addr == 2'd2, "R10 address held while valid", 32'(fifo_addr), 32'h2);
        ep_sel = 2'd2;
        @(negedge clk);
        in_valid = 1'b0;
        fifo_full = 1'b0;
        idle(3);
        chk(fifo_addr == 2'd2, "R10 address after release", 32'(fifo_addr), 32'h2);

        // R9: stretched packet-end and recovery
        async_mode = 1'b1;
        send(16'hAA55, 1'b1);
        while (pkt_end) @(negedge clk);
        lo = 0;
        while (!in_ready && lo < 100) begin
            lo++;
            @(negedge clk);
        end
        chk(lo == PW, "R9 recovery length", 32'(lo), 32'(PW));
        async_mode = 1'b0;
        idle(4);

        chk(exp_q.size() == 0, "R2 all expected outputs seen", 32'(exp_q.size()), 32'h0);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule